// File: doc/BRIEF.md
# Aliased Set/Clear Control Register Bank for a USB Transceiver

This block holds two 8-bit control registers that a link controller programs over a simple single-cycle register port. The first is the function-control register: speed select, termination select, operating mode, a transceiver reset request and a suspend control. The second is the interface-control register, which holds three alternate interface-mode enables. Each register is mapped at three consecutive addresses. A write to the first address replaces the value. A write to the second ORs the data into the register. A write to the third clears every bit where the data has a one. A read at any of the three addresses returns the current value.

The PHY core reports events as single-cycle pulses, and these change the bank without software. When a transceiver reset completes, the reset request bit clears. When low-power mode ends, the suspend control bit is set again. When the PHY leaves a mode, that mode's enable clears. If a hardware event and a software access hit the same bit in the same cycle, the hardware event wins. The register bits drive level outputs to the PHY core directly from flops. Address 00h returns a fixed identification byte.

Top module: `phy_ctrl_regs`

## Requirements
- R1: Synchronous reset (rst high at a clock edge) sets function control to 0x41 and interface control to 0x00. After reset, xcvr_sel=01, suspend_req=0, and all other control outputs are 0.
- R2: A write (wr=1) to FUNC_BASE (04h) or IFC_BASE (07h) loads wdata into that register. Read-only bits are excluded from the load.
- R3: A write to base+1 (05h/08h) ORs wdata into the register. A write to base+2 (06h/09h) clears the bits where wdata is 1.
- R4: rdata is registered. It updates one cycle after a cycle with rd=1, using the register value from before any write in that same cycle. While rd=0, rdata holds its value. All three aliased addresses of a register read its current value.
- R5: Function-control bit 7 and interface-control bits 7:3 always read 0. No write, set or clear changes them.
- R6: xcvr_reset equals function-control bit 5. A reset_done pulse clears bit 5 at the next edge, even if software sets bit 5 in the same cycle.
- R7: suspend_req equals the inverse of function-control bit 6. A lowpower_exit pulse sets bit 6 at the next edge, even if software clears bit 6 in the same cycle.
- R8: serial6_en, serial3_en and carkit_en equal interface-control bits 0, 1 and 2. A serial6_exit, serial3_exit or carkit_exit pulse clears only its own bit at the next edge, overriding a software set in the same cycle.
- R9: A read of address 00h returns PRODUCT_ID. A read of any other address outside 04h-09h returns 0. Writes to addresses outside 04h-09h change no register.
- R10: xcvr_sel is function-control bits 1:0 (00 HS, 01 FS, 10 LS, 11 FS carrying LS packets). term_sel is bit 2. op_mode is bits 4:3 (00 normal, 01 non-driving, 10 stuffing and NRZI off, 11 reserved).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Register address |
| wdata | input | DATA_W | Write data or bit mask |
| wr | input | 1 | Write strobe, one cycle |
| rd | input | 1 | Read strobe, one cycle |
| rdata | output | DATA_W | Registered read data |
| reset_done | input | 1 | Pulse: transceiver reset finished |
| lowpower_exit | input | 1 | Pulse: low-power mode ended |
| serial6_exit | input | 1 | Pulse: PHY left 6-pin serial mode |
| serial3_exit | input | 1 | Pulse: PHY left 3-pin serial mode |
| carkit_exit | input | 1 | Pulse: PHY left carkit mode |
| xcvr_sel | output | 2 | Transceiver speed select |
| term_sel | output | 1 | Termination select |
| op_mode | output | 2 | Transmit encoding mode |
| xcvr_reset | output | 1 | Transceiver reset request |
| suspend_req | output | 1 | Low-power request (inverse of suspend control bit) |
| serial6_en | output | 1 | 6-pin serial mode enable |
| serial3_en | output | 1 | 3-pin serial mode enable |
| carkit_en | output | 1 | Carkit mode enable |

## Verification
Every register bit drives a port directly from its flop. A wrong value after a write, set, clear or hardware pulse therefore shows on the control outputs at the very next sample. It shows again on rdata one cycle after a read at any of the three aliases. A decode fault that sends a write to the wrong alias, or lets an unmapped write reach a register, changes an output or a read-back within two cycles. A lost hardware priority leaves xcvr_reset, suspend_req or a mode enable at the wrong level in the cycle after the collision.

// File: rtl/phy_regs_pkg.sv
package phy_regs_pkg;
  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_SET   = 2'd1,
    ACC_CLEAR = 2'd2,
    ACC_NONE  = 2'd3
  } acc_e;

  localparam int NUM_REGS  = 2;
  localparam int REG_FUNC  = 0;
  localparam int REG_IFC   = 1;
  localparam int ALIASES   = 3;

  localparam int FB_XSEL_LO  = 0;
  localparam int FB_TERM     = 2;
  localparam int FB_OPM_LO   = 3;
  localparam int FB_RESET    = 5;
  localparam int FB_SUSPENDM = 6;

  localparam int IB_SER6   = 0;
  localparam int IB_SER3   = 1;
  localparam int IB_CARKIT = 2;
endpackage

// File: rtl/phy_reg_decode.sv
module phy_reg_decode
  import phy_regs_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int FUNC_BASE = 4,
  parameter int IFC_BASE  = 7
) (
  input  logic [ADDR_W-1:0]   addr,
  output acc_e                kind [NUM_REGS],
  output logic [NUM_REGS-1:0] sel,
  output logic                hit_id
);
  localparam int BASES [NUM_REGS] = '{FUNC_BASE, IFC_BASE};

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
    logic [ADDR_W-1:0] off;
    assign off    = addr - ADDR_W'(BASES[i]);
    assign sel[i] = (int'(addr) >= BASES[i]) && (int'(off) < ALIASES);
    assign kind[i] = sel[i] ? acc_e'(off[1:0]) : ACC_NONE;
  end

  assign hit_id = (addr == '0);
endmodule

// File: rtl/phy_alias_reg.sv
module phy_alias_reg
  import phy_regs_pkg::*;
#(
  parameter int              W       = 8,
  parameter logic [W-1:0]    RST_VAL = '0,
  parameter logic [W-1:0]    RO_MASK = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  acc_e         kind,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] hw_clr,
  input  logic [W-1:0] hw_set,
  output logic [W-1:0] q
);
  logic [W-1:0] sw_val;
  logic [W-1:0] nxt;

  always_comb begin
    sw_val = q;
    if (we) begin
      unique case (kind)
        ACC_LOAD:  sw_val = wdata;
        ACC_SET:   sw_val = q | wdata;
        ACC_CLEAR: sw_val = q & ~wdata;
        default:   sw_val = q;
      endcase
    end
    nxt = ((sw_val & ~hw_clr) | hw_set) & ~RO_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= RST_VAL & ~RO_MASK;
    else     q <= nxt;
  end
endmodule

// File: rtl/phy_read_mux.sv
module phy_read_mux
  import phy_regs_pkg::*;
#(
  parameter int           W          = 8,
  parameter logic [W-1:0] PRODUCT_ID = 8'h24
) (
  input  logic [NUM_REGS-1:0]        sel,
  input  logic                       hit_id,
  input  logic [NUM_REGS-1:0][W-1:0] regs,
  output logic [W-1:0]               data
);
  always_comb begin
    data = '0;
    if (hit_id) data = PRODUCT_ID;
    for (int i = 0; i < NUM_REGS; i++)
      if (sel[i]) data = regs[i];
  end
endmodule

// File: rtl/phy_ctrl_regs.sv
module phy_ctrl_regs
  import phy_regs_pkg::*;
#(
  parameter int                ADDR_W     = 6,
  parameter int                DATA_W     = 8,
  parameter logic [DATA_W-1:0] PRODUCT_ID = 8'h24,
  parameter int                FUNC_BASE  = 4,
  parameter int                IFC_BASE   = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr,
  input  logic              rd,
  output logic [DATA_W-1:0] rdata,
  input  logic              reset_done,
  input  logic              lowpower_exit,
  input  logic              serial6_exit,
  input  logic              serial3_exit,
  input  logic              carkit_exit,
  output logic [1:0]        xcvr_sel,
  output logic              term_sel,
  output logic [1:0]        op_mode,
  output logic              xcvr_reset,
  output logic              suspend_req,
  output logic              serial6_en,
  output logic              serial3_en,
  output logic              carkit_en
);
  localparam logic [DATA_W-1:0] FUNC_RST = DATA_W'(8'h41);
  localparam logic [DATA_W-1:0] FUNC_RO  = ~(DATA_W'(8'h7F));
  localparam logic [DATA_W-1:0] IFC_RO   = ~(DATA_W'(8'h07));

  acc_e                             kind [NUM_REGS];
  logic [NUM_REGS-1:0]              sel;
  logic                             hit_id;
  logic [NUM_REGS-1:0][DATA_W-1:0]  regs;
  logic [NUM_REGS-1:0][DATA_W-1:0]  hw_clr;
  logic [NUM_REGS-1:0][DATA_W-1:0]  hw_set;
  logic [DATA_W-1:0]                rd_data;

  phy_reg_decode #(.ADDR_W(ADDR_W), .FUNC_BASE(FUNC_BASE), .IFC_BASE(IFC_BASE)) u_dec (
    .addr(addr), .kind(kind), .sel(sel), .hit_id(hit_id)
  );

  always_comb begin
    hw_clr = '0;
    hw_set = '0;
    hw_clr[REG_FUNC][FB_RESET]    = reset_done;
    hw_set[REG_FUNC][FB_SUSPENDM] = lowpower_exit;
    hw_clr[REG_IFC][IB_SER6]      = serial6_exit;
    hw_clr[REG_IFC][IB_SER3]      = serial3_exit;
    hw_clr[REG_IFC][IB_CARKIT]    = carkit_exit;
  end

  localparam logic [NUM_REGS-1:0][DATA_W-1:0] RST_VALS = {{DATA_W{1'b0}}, FUNC_RST};
  localparam logic [NUM_REGS-1:0][DATA_W-1:0] RO_VALS  = {IFC_RO, FUNC_RO};

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    phy_alias_reg #(.W(DATA_W), .RST_VAL(RST_VALS[i]), .RO_MASK(RO_VALS[i])) u_reg (
      .clk(clk), .rst(rst), .we(wr), .kind(kind[i]), .wdata(wdata),
      .hw_clr(hw_clr[i]), .hw_set(hw_set[i]), .q(regs[i])
    );
  end

  phy_read_mux #(.W(DATA_W), .PRODUCT_ID(PRODUCT_ID)) u_mux (
    .sel(sel), .hit_id(hit_id), .regs(regs), .data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rd_data;
  end

  assign xcvr_sel    = regs[REG_FUNC][FB_XSEL_LO +: 2];
  assign term_sel    = regs[REG_FUNC][FB_TERM];
  assign op_mode     = regs[REG_FUNC][FB_OPM_LO +: 2];
  assign xcvr_reset  = regs[REG_FUNC][FB_RESET];
  assign suspend_req = ~regs[REG_FUNC][FB_SUSPENDM];
  assign serial6_en  = regs[REG_IFC][IB_SER6];
  assign serial3_en  = regs[REG_IFC][IB_SER3];
  assign carkit_en   = regs[REG_IFC][IB_CARKIT];
endmodule

// File: rtl/phy_ctrl_regs_chk.sv
module phy_ctrl_regs_chk #(
  parameter int                ADDR_W     = 6,
  parameter int                DATA_W     = 8,
  parameter logic [DATA_W-1:0] PRODUCT_ID = 8'h24,
  parameter int                FUNC_BASE  = 4,
  parameter int                IFC_BASE   = 7
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              wr,
  input logic              rd,
  input logic [DATA_W-1:0] rdata,
  input logic              reset_done,
  input logic              lowpower_exit,
  input logic              serial6_exit,
  input logic              serial3_exit,
  input logic              carkit_exit,
  input logic [1:0]        xcvr_sel,
  input logic              term_sel,
  input logic [1:0]        op_mode,
  input logic              xcvr_reset,
  input logic              suspend_req,
  input logic              serial6_en,
  input logic              serial3_en,
  input logic              carkit_en
);
  logic in_func, unmapped, any_ev;
  logic [8:0] outs;
  assign in_func  = (int'(addr) >= FUNC_BASE) && (int'(addr) < FUNC_BASE + 3);
  assign unmapped = !in_func && !((int'(addr) >= IFC_BASE) && (int'(addr) < IFC_BASE + 3));
  assign any_ev   = reset_done | lowpower_exit | serial6_exit | serial3_exit | carkit_exit;
  assign outs     = {xcvr_sel, term_sel, op_mode, xcvr_reset, suspend_req, serial6_en, serial3_en} ^ {8'd0, carkit_en};

  assert_hold_rdata_R4: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(rdata));
  assert_ro_bit_R5: assert property (@(posedge clk) disable iff (rst)
    (rd && in_func) |=> (rdata[DATA_W-1] == 1'b0));
  assert_reset_done_R6: assert property (@(posedge clk) disable iff (rst)
    reset_done |=> !xcvr_reset);
  assert_lowpower_exit_R7: assert property (@(posedge clk) disable iff (rst)
    lowpower_exit |=> !suspend_req);
  assert_serial6_exit_R8: assert property (@(posedge clk) disable iff (rst)
    serial6_exit |=> !serial6_en);
  assert_serial3_exit_R8: assert property (@(posedge clk) disable iff (rst)
    serial3_exit |=> !serial3_en);
  assert_carkit_exit_R8: assert property (@(posedge clk) disable iff (rst)
    carkit_exit |=> !carkit_en);
  assert_id_read_R9: assert property (@(posedge clk) disable iff (rst)
    (rd && addr == '0) |=> (rdata == PRODUCT_ID));
  assert_unmapped_write_R9: assert property (@(posedge clk) disable iff (rst)
    (wr && unmapped && !any_ev) |=> ($stable(outs) && $stable(carkit_en)));
endmodule

bind phy_ctrl_regs phy_ctrl_regs_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRODUCT_ID(PRODUCT_ID),
  .FUNC_BASE(FUNC_BASE), .IFC_BASE(IFC_BASE)
) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .wr(wr), .rd(rd), .rdata(rdata),
  .reset_done(reset_done), .lowpower_exit(lowpower_exit),
  .serial6_exit(serial6_exit), .serial3_exit(serial3_exit), .carkit_exit(carkit_exit),
  .xcvr_sel(xcvr_sel), .term_sel(term_sel), .op_mode(op_mode),
  .xcvr_reset(xcvr_reset), .suspend_req(suspend_req),
  .serial6_en(serial6_en), .serial3_en(serial3_en), .carkit_en(carkit_en)
);

// File: tb/test_phy_ctrl_regs.sv
`timescale 1ns/1ps
module test_phy_ctrl_regs;
  localparam logic [7:0] ID = 8'h24;
  localparam logic [7:0] FM = 8'h7F;
  localparam logic [7:0] IM = 8'h07;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [7:0] rdata;
  logic reset_done = 0, lowpower_exit = 0, serial6_exit = 0, serial3_exit = 0, carkit_exit = 0;
  logic [1:0] xcvr_sel, op_mode;
  logic term_sel, xcvr_reset, suspend_req, serial6_en, serial3_en, carkit_en;

  int n_chk = 0, n_bad = 0;
  logic [7:0] fexp, iexp;

  always #2 clk = ~clk;

  phy_ctrl_regs #(.PRODUCT_ID(ID)) i_phy_ctrl_regs (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr(wr), .rd(rd), .rdata(rdata),
    .reset_done(reset_done), .lowpower_exit(lowpower_exit), .serial6_exit(serial6_exit),
    .serial3_exit(serial3_exit), .carkit_exit(carkit_exit),
    .xcvr_sel(xcvr_sel), .term_sel(term_sel), .op_mode(op_mode), .xcvr_reset(xcvr_reset),
    .suspend_req(suspend_req), .serial6_en(serial6_en), .serial3_en(serial3_en), .carkit_en(carkit_en)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic chk_outs(input string req);
    chk(req, {1'b0, ~suspend_req, xcvr_reset, op_mode, term_sel, xcvr_sel}, fexp);
    chk(req, {5'b0, carkit_en, serial3_en, serial6_en}, iexp);
  endtask

  // one bus cycle: ev = {carkit, serial3, serial6, lowpower, reset_done}
  task automatic cyc(input logic [5:0] a, input logic [7:0] d, input logic w,
                     input logic r, input logic [4:0] ev);
    @(negedge clk);
    addr = a; wdata = d; wr = w; rd = r;
    {carkit_exit, serial3_exit, serial6_exit, lowpower_exit, reset_done} = ev;
    @(negedge clk);
    wr = 0; rd = 0;
    {carkit_exit, serial3_exit, serial6_exit, lowpower_exit, reset_done} = '0;
  endtask

  task automatic rchk(input string req, input logic [5:0] a, input logic [7:0] exp);
    cyc(a, 8'h00, 1'b0, 1'b1, 5'b0);
    chk(req, rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    fexp = 8'h41; iexp = 8'h00;
    chk_outs("R1 reset outputs");
    for (int a = 4; a < 7; a++) rchk("R1 func reset", 6'(a), 8'h41);
    for (int a = 7; a < 10; a++) rchk("R1 ifc reset", 6'(a), 8'h00);

    // plain load sweep
    for (int v = 0; v < 256; v++) begin
      cyc(6'h04, 8'(v), 1, 0, 0); fexp = 8'(v) & FM;
      chk_outs("R2 R10 func load outputs");
      rchk("R2 R5 func load readback", 6'(4 + v % 3), fexp);
      cyc(6'h07, 8'(v), 1, 0, 0); iexp = 8'(v) & IM;
      chk_outs("R2 R8 ifc load outputs");
      rchk("R2 R5 ifc load readback", 6'(7 + v % 3), iexp);
    end

    // set / clear sweep
    for (int v = 0; v < 256; v++) begin
      logic [7:0] m, c;
      m = 8'((v * 37 + 11) & 255);
      c = m ^ 8'h5A;
      cyc(6'h04, 8'(v), 1, 0, 0); fexp = 8'(v) & FM;
      cyc(6'h05, m, 1, 0, 0);     fexp = (fexp | m) & FM;
      rchk("R3 func set", 6'h05, fexp);
      cyc(6'h06, c, 1, 0, 0);     fexp = fexp & ~c;
      rchk("R3 func clear", 6'h06, fexp);
      chk_outs("R3 func outputs");
      cyc(6'h07, 8'(v), 1, 0, 0); iexp = 8'(v) & IM;
      cyc(6'h08, m, 1, 0, 0);     iexp = (iexp | m) & IM;
      rchk("R3 ifc set", 6'h08, iexp);
      cyc(6'h09, c, 1, 0, 0);     iexp = iexp & ~c;
      rchk("R3 ifc clear", 6'h09, iexp);
      chk_outs("R3 ifc outputs");
    end

    // read during write returns old value; hold when rd low
    cyc(6'h04, 8'h00, 1, 0, 0);
    cyc(6'h04, 8'h15, 1, 1, 0); fexp = 8'h15;
    chk("R4 read-before-write", rdata, 8'h00);
    rchk("R4 new value", 6'h06, 8'h15);
    cyc(6'h07, 8'h03, 1, 0, 0); iexp = 8'h03;
    chk("R4 hold rdata", rdata, 8'h15);

    // R6 reset_done
    cyc(6'h05, 8'h20, 1, 0, 0); fexp = 8'h35;
    chk("R6 xcvr_reset high", {7'd0, xcvr_reset}, 8'h01);
    cyc(6'h00, 8'h00, 0, 0, 5'b00001); fexp = 8'h15;
    chk_outs("R6 reset_done clears");
    cyc(6'h05, 8'h20, 1, 0, 5'b00001);
    chk_outs("R6 hw beats sw set");
    rchk("R6 readback", 6'h04, 8'h15);

    // R7 lowpower_exit
    cyc(6'h06, 8'h40, 1, 0, 0); fexp = 8'h15;
    cyc(6'h05, 8'h00, 1, 0, 0);
    chk("R7 suspend_req high", {7'd0, suspend_req}, 8'h01);
    cyc(6'h00, 8'h00, 0, 0, 5'b00010); fexp = 8'h55;
    chk_outs("R7 lowpower_exit sets");
    cyc(6'h06, 8'h40, 1, 0, 5'b00010);
    chk_outs("R7 hw beats sw clear");
    rchk("R7 readback", 6'h05, 8'h55);

    // R8 mode exits
    cyc(6'h08, 8'h07, 1, 0, 0); iexp = 8'h07;
    chk_outs("R8 all modes on");
    cyc(6'h00, 8'h00, 0, 0, 5'b00100); iexp = 8'h06;
    chk_outs("R8 serial6 exit");
    cyc(6'h00, 8'h00, 0, 0, 5'b01000); iexp = 8'h04;
    chk_outs("R8 serial3 exit");
    cyc(6'h00, 8'h00, 0, 0, 5'b10000); iexp = 8'h00;
    chk_outs("R8 carkit exit");
    cyc(6'h08, 8'h07, 1, 0, 5'b01000); iexp = 8'h05;
    chk_outs("R8 hw beats sw set");
    rchk("R8 readback", 6'h09, 8'h05);

    // R9 unmapped
    cyc(6'h04, 8'h2A, 1, 0, 0); fexp = 8'h2A;
    for (int a = 0; a < 64; a++) begin
      if (a >= 4 && a < 10) continue;
      cyc(6'(a), 8'hFF, 1, 0, 0);
      chk_outs("R9 unmapped write ignored");
      rchk("R9 unmapped read", 6'(a), (a == 0) ? ID : 8'h00);
    end
    rchk("R9 func intact", 6'h04, 8'h2A);
    rchk("R9 ifc intact", 6'h07, 8'h05);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule